// File: doc/BRIEF.md
# Glitch-free clock divider

This block divides a fast reference clock by an even ratio and delivers a slower clock with a 50% duty cycle. With the default setting, a 200 MHz reference becomes a 1 MHz output, which is a division by 200. Internally, a cycle counter runs through one half-period and produces a single-cycle toggle pulse when it reaches its terminal value. A two-state Moore machine moves between its low and high states on each of these pulses.

The output pin is wired directly to the state flip-flop, with no gates between them. Decode hazards therefore cannot produce a runt pulse on the generated clock. Reset is synchronous and active high. While reset is held, the counter is cleared and the output is held low. Reset also wins over a toggle that is due in the same cycle.

Top module: `glitchfree_clk_divider`

## Requirements
- R1: While rst is sampled high at a rising clk_in edge, clk_out is 0 after that edge and the internal count is 0, however long reset is held.
- R2: After reset is released, the first rising edge of clk_out follows the 100th rising edge of clk_in (HALF_PERIOD = 100).
- R3: Each high phase of clk_out lasts exactly 100 clk_in cycles.
- R4: Each low phase of clk_out after the first rise lasts exactly 100 clk_in cycles.
- R5: The distance between consecutive rising edges of clk_out is exactly 200 clk_in cycles.
- R6: clk_out changes only in the same time step as a rising clk_in edge, and only on an edge where the counter issued its toggle pulse.
- R7: If reset is asserted in the cycle where a toggle is due (count at 99), clk_out stays 0, and the next rise again comes 100 cycles after release.
- R8: Asserting reset during a high phase forces clk_out to 0 at the next clk_in edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| clk_out | output | 1 | Divided clock, driven straight from the state flop |

## Verification
The terminal-count toggle and the synchronous reset can occur on the same clk_in edge. The bench creates this collision by counting 99 edges after release and asserting reset at the falling edge just before the 100th. The correct outcome is that clk_out stays low after that edge. After reset is released again, the first rise must come a full 100 cycles later, which shows that the counter was also cleared and did not carry over a partial count. A second collision, reset during a high phase, is judged by clk_out dropping to 0 at the very next edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   function automatic int unsigned cnt_width(input int unsigned terminal);
      if (terminal <= 2) return 1;
      return $clog2(terminal);
   endfunction

endpackage

// File: rtl/clkdiv_cycle_counter.sv
module clkdiv_cycle_counter #(
   parameter int unsigned TERMINAL = 100,
   parameter int unsigned CNT_W    = 7
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TERMINAL - 1);

   initial begin
      if (TERMINAL < 2)
         $error("clkdiv_cycle_counter: TERMINAL must be at least 2");
      if ((64'd1 << CNT_W) < 64'(TERMINAL))
         $error("clkdiv_cycle_counter: CNT_W too narrow for TERMINAL");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (at_last) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   assign tick = at_last && !rst;

   // R1: reset leaves the count at zero
   a_r1_cnt_cleared: assert property (@(posedge clk) rst |=> (cnt_q == '0));

   // R3 / R4: count never leaves the half-period range, so phases cannot stretch
   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      (cnt_q <= LAST));

   // R2: a pulse is always followed by a fresh count from zero
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == '0));

endmodule

// File: rtl/clkdiv_phase_reg.sv
module clkdiv_phase_reg
   import clkdiv_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic toggle,
   output logic phase
);

   phase_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (toggle) begin
         case (st_q)
            PH_LOW:  st_d = PH_HIGH;
            PH_HIGH: st_d = PH_LOW;
            default: st_d = PH_LOW;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= PH_LOW;
      else     st_q <= st_d;
   end

   assign phase = st_q;

   // R7 / R8: reset dominates any pending toggle
   a_r7_reset_wins: assert property (@(posedge clk) rst |=> (phase == 1'b0));

endmodule

// File: rtl/glitchfree_clk_divider.sv
module glitchfree_clk_divider #(
   parameter int unsigned HALF_PERIOD = 100
) (
   input  logic clk_in,
   input  logic rst,
   output logic clk_out
);

   localparam int unsigned CNT_W = clkdiv_pkg::cnt_width(HALF_PERIOD);

   initial begin
      if (HALF_PERIOD < 1)
         $error("glitchfree_clk_divider: HALF_PERIOD must be at least 1");
   end

   logic tick;
   logic phase;

   generate
      if (HALF_PERIOD == 1) begin : g_every_cycle
         assign tick = !rst;
      end else begin : g_counted
         clkdiv_cycle_counter #(
            .TERMINAL (HALF_PERIOD),
            .CNT_W    (CNT_W)
         ) cnt_i (
            .clk  (clk_in),
            .rst  (rst),
            .tick (tick)
         );
      end
   endgenerate

   clkdiv_phase_reg phase_i (
      .clk    (clk_in),
      .rst    (rst),
      .toggle (tick),
      .phase  (phase)
   );

   assign clk_out = phase;

   // R6: the output moves only on an edge where a toggle pulse was present
   a_r6_change_needs_tick: assert property (@(posedge clk_in) disable iff (rst)
      (clk_out != $past(clk_out)) |-> ($past(tick) || $past(rst)));

   // R1: held reset keeps the output low
   a_r1_out_low: assert property (@(posedge clk_in) rst |=> !clk_out);

endmodule

// File: tb/glitchfree_clk_divider_tb.sv
module glitchfree_clk_divider_tb_top;

   localparam int HALF = 100;
   localparam int NV   = 10;
   // {cycles after release at which clk_out changes, new level}
   localparam int VEC [NV][2] = '{
      '{100, 1}, '{200, 0}, '{300, 1}, '{400, 0}, '{500, 1},
      '{600, 0}, '{700, 1}, '{800, 0}, '{900, 1}, '{1000, 0}
   };

   logic clk_in = 1'b0;
   logic rst    = 1'b1;
   logic clk_out;

   int checks = 0;
   int errors = 0;
   int glitches = 0;
   bit watch_on = 0;
   time last_pos = 0;

   always #4 clk_in = ~clk_in;

   glitchfree_clk_divider #(.HALF_PERIOD(HALF)) dut_i (
      .clk_in  (clk_in),
      .rst     (rst),
      .clk_out (clk_out)
   );

   always @(posedge clk_in) last_pos = $time;

   // R6 monitor: any change away from a rising clk_in time step is a glitch
   always @(clk_out) if (watch_on && ($time != last_pos)) glitches++;

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // waits until clk_out differs from its value at entry; n counts negedges
   task automatic wait_change(inout int n);
      logic prev;
      prev = clk_out;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk_in);
         n++;
         if (clk_out !== prev) return;
      end
   endtask

   initial begin
      int n;
      int last_n;
      int last_rise;
      bit held_low;

      // R1: long reset, output low throughout
      held_low = 1;
      repeat (250) begin
         @(negedge clk_in);
         if (clk_out !== 1'b0) held_low = 0;
      end
      watch_on = 1;
      chk(held_low, "R1 low during reset", held_low, 1);

      // release and walk the vector table
      rst = 1'b0;
      n = 0; last_n = 0; last_rise = 0;
      for (int i = 0; i < NV; i++) begin
         wait_change(n);
         if (i == 0)
            chk(n == VEC[i][0], "R2 first rise", n, VEC[i][0]);
         else
            chk(n == VEC[i][0], "R5 edge position", n, VEC[i][0]);
         chk(clk_out === VEC[i][1][0], "R6 level", int'(clk_out), VEC[i][1]);
         if (i > 0) begin
            if (clk_out === 1'b0)
               chk(n - last_n == HALF, "R3 high width", n - last_n, HALF);
            else
               chk(n - last_n == HALF, "R4 low width", n - last_n, HALF);
         end
         if (clk_out === 1'b1) begin
            if (i > 0) chk(n - last_rise == 2*HALF, "R5 period", n - last_rise, 2*HALF);
            last_rise = n;
         end
         last_n = n;
      end

      // R7: reset lands on the cycle where the toggle is due
      rst = 1'b1;
      repeat (3) @(negedge clk_in);
      rst = 1'b0;
      repeat (HALF - 1) @(negedge clk_in);   // count now at 99, toggle pending
      chk(clk_out === 1'b0, "R7 before collision", int'(clk_out), 0);
      rst = 1'b1;
      @(negedge clk_in);
      chk(clk_out === 1'b0, "R7 reset beats toggle", int'(clk_out), 0);
      rst = 1'b0;
      n = 0;
      wait_change(n);
      chk(n == HALF, "R7 restart first rise", n, HALF);
      chk(clk_out === 1'b1, "R7 restart level", int'(clk_out), 1);

      // R8: reset in the middle of a high phase
      repeat (50) @(negedge clk_in);
      chk(clk_out === 1'b1, "R8 still high", int'(clk_out), 1);
      rst = 1'b1;
      @(negedge clk_in);
      chk(clk_out === 1'b0, "R8 forced low", int'(clk_out), 0);
      repeat (2) @(negedge clk_in);
      rst = 1'b0;
      n = 0;
      wait_change(n);
      chk(n == HALF, "R2 rise after mid-high reset", n, HALF);

      chk(glitches == 0, "R6 changes only at clk_in rise", glitches, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule